// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Aspect Ratio

This block is a true dual-port synchronous memory. Port A and port B each have their own enable, write enable, address, write data and read data. They share nothing but the stored array. Each port is built at its own data width over the same number of total bits, so the narrow port sees more, shorter words and the wide port sees fewer, longer ones. Every input is sampled on the rising clock edge, and nothing at the ports changes between edges.

The storage is kept as lanes as wide as the narrower port. A wide word is a group of adjacent lanes. The lowest-addressed lane sits in the least significant bits of the wide word, so the low bits of a narrow address pick the lane inside a wide word.

Each port has its own write mode, fixed at elaboration, which decides what its read data shows on a write:
- `WM_READ_FIRST` shows the word held before the write.
- `WM_WRITE_FIRST` shows the word being written.
- `WM_NO_CHANGE` keeps the previous output.

Each port can add an output pipeline register, which costs one cycle of latency. Both ports run from one clock.

Top module: `dpram_dual`

## Requirements
- R1: While reset is low, both read-data outputs are zero. Reset does not clear the stored array.
- R2: On a port without an output register, read data for an operation enabled at edge N is visible after edge N. A port with the output register shows it after edge N+1, and after edge N it still shows the previous result.
- R3: A port whose enable is low at an edge writes nothing, even with write enable high, and its read data holds its previous value.
- R4: On a port in `WM_READ_FIRST` mode, an enabled write returns the word stored at that address before the write. An enabled read returns the stored word.
- R5: On a port in `WM_WRITE_FIRST` mode, an enabled write returns the word being written.
- R6: On a port in `WM_NO_CHANGE` mode, an enabled write leaves the read data unchanged. An enabled read returns the stored word.
- R7: With the default widths (A 8 bits, 128 words; B 32 bits, 32 words), bits [8k+7:8k] of B word w are the same storage as A address 4w+k, for k = 0 to 3.
- R8: A write through the narrow port changes only its own lane of the wide word. The other lanes keep their contents.
- R9: A read on one port of an address that the other port writes at the same edge returns the contents from before that write. Both ports writing the same storage at the same edge is not allowed.
- R10: Contents written before a reset read back unchanged after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| a_en | input | 1 | Port A operation enable |
| a_we | input | 1 | Port A write enable (acts only with a_en) |
| a_addr | input | A_AW (7) | Port A word address |
| a_wdata | input | A_DW (8) | Port A write data |
| a_rdata | output | A_DW (8) | Port A read data |
| b_en | input | 1 | Port B operation enable |
| b_we | input | 1 | Port B write enable (acts only with b_en) |
| b_addr | input | B_AW (5) | Port B word address |
| b_wdata | input | B_DW (32) | Port B write data |
| b_rdata | output | B_DW (32) | Port B read data |

## Verification
A wrong lane index or a wrong lane order corrupts data without stopping anything. It shows up only on the next read of the affected word from the other port, one or two cycles after that read is enabled. A wrong write-mode choice or a missing hold shows on the same port's read data one cycle after the write or idle edge. A missing or extra pipeline stage moves every result on that port by one cycle, so the first back-to-back reads of different words expose it. Every output is compared on every cycle, which catches these faults at the first cycle they appear.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Behaviour of a port's read data during a write on that same port
    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/dpram_lane_array.sv
module dpram_lane_array #(
    parameter int LW     = 8,
    parameter int NLANES = 128,
    parameter int A_R    = 1,
    parameter int B_R    = 4,
    localparam int LAW   = $clog2(NLANES),
    localparam int A_SH  = $clog2(A_R),
    localparam int B_SH  = $clog2(B_R),
    localparam int A_AW  = LAW - A_SH,
    localparam int B_AW  = LAW - B_SH
) (
    input  logic                 clk,
    input  logic                 a_en,
    input  logic                 a_we,
    input  logic [A_AW-1:0]      a_addr,
    input  logic [A_R*LW-1:0]    a_wdata,
    output logic [A_R*LW-1:0]    a_rword,
    input  logic                 b_en,
    input  logic                 b_we,
    input  logic [B_AW-1:0]      b_addr,
    input  logic [B_R*LW-1:0]    b_wdata,
    output logic [B_R*LW-1:0]    b_rword
);

    logic [LW-1:0]  mem [NLANES];
    logic [LAW-1:0] a_base;
    logic [LAW-1:0] b_base;

    // R7: lane base of a word; lane k of the word occupies bits [k*LW +: LW]
    assign a_base = LAW'(a_addr) << A_SH;
    assign b_base = LAW'(b_addr) << B_SH;

    // R9: reads see the array contents from before this edge's writes
    always_comb begin
        for (int k = 0; k < A_R; k++) begin
            a_rword[k*LW +: LW] = mem[a_base + LAW'(k)];
        end
        for (int k = 0; k < B_R; k++) begin
            b_rword[k*LW +: LW] = mem[b_base + LAW'(k)];
        end
    end

    // R3, R8: only the lanes of an enabled write are touched
    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            for (int k = 0; k < A_R; k++) begin
                mem[a_base + LAW'(k)] <= a_wdata[k*LW +: LW];
            end
        end
        if (b_en && b_we) begin
            for (int k = 0; k < B_R; k++) begin
                mem[b_base + LAW'(k)] <= b_wdata[k*LW +: LW];
            end
        end
    end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
    parameter int                DW      = 8,
    parameter dpram_pkg::wmode_e MODE    = dpram_pkg::WM_READ_FIRST,
    parameter bit                OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rword,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] lat;

    // R1: cleared by reset; R3: held unless enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (en) begin
            if (!we) begin
                lat <= rword;
            end else begin
                unique case (MODE)
                    dpram_pkg::WM_READ_FIRST:  lat <= rword;
                    dpram_pkg::WM_WRITE_FIRST: lat <= wdata;
                    dpram_pkg::WM_NO_CHANGE:   lat <= lat;
                    default:                   lat <= lat;
                endcase
            end
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [DW-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= lat;
            end
            assign dout = pipe_q;

            // R2
            pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (dout == $past(lat)));
        end else begin : g_direct
            assign dout = lat;
        end

        if (MODE == dpram_pkg::WM_READ_FIRST) begin : g_rf
            // R4
            rf_old_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
                en |=> (lat == $past(rword)));
        end else if (MODE == dpram_pkg::WM_WRITE_FIRST) begin : g_wf
            // R5
            wf_new_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (lat == $past(wdata)));
        end else begin : g_nc
            // R6
            nc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> $stable(lat));
        end
    endgenerate

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lat));

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
    parameter int                A_DW       = 8,
    parameter int                B_DW       = 32,
    parameter int                TOTAL_BITS = 1024,
    parameter dpram_pkg::wmode_e A_MODE     = dpram_pkg::WM_READ_FIRST,
    parameter dpram_pkg::wmode_e B_MODE     = dpram_pkg::WM_WRITE_FIRST,
    parameter bit                A_OUT_REG  = 1'b0,
    parameter bit                B_OUT_REG  = 1'b1,
    localparam int LW     = (A_DW < B_DW) ? A_DW : B_DW,
    localparam int NLANES = TOTAL_BITS / LW,
    localparam int A_R    = A_DW / LW,
    localparam int B_R    = B_DW / LW,
    localparam int A_AW   = $clog2(TOTAL_BITS / A_DW),
    localparam int B_AW   = $clog2(TOTAL_BITS / B_DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_en,
    input  logic            a_we,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_DW-1:0] a_wdata,
    output logic [A_DW-1:0] a_rdata,
    input  logic            b_en,
    input  logic            b_we,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_DW-1:0] b_wdata,
    output logic [B_DW-1:0] b_rdata
);

    logic [A_DW-1:0] a_rword;
    logic [B_DW-1:0] b_rword;

    dpram_lane_array #(
        .LW(LW), .NLANES(NLANES), .A_R(A_R), .B_R(B_R)
    ) u_array (
        .clk(clk),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rword(a_rword),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rword(b_rword)
    );

    dpram_port_out #(.DW(A_DW), .MODE(A_MODE), .OUT_REG(A_OUT_REG)) u_out_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
        .wdata(a_wdata), .rword(a_rword), .dout(a_rdata)
    );

    dpram_port_out #(.DW(B_DW), .MODE(B_MODE), .OUT_REG(B_OUT_REG)) u_out_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we),
        .wdata(b_wdata), .rword(b_rword), .dout(b_rdata)
    );

endmodule

// File: tb/sim_dpram_dual.sv
module sim_dpram_dual;

    localparam int CLK_P = 10;
    localparam int NL    = 128;
    localparam int NW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [6:0]  a_addr = '0;
    logic [7:0]  a_wd = '0;
    logic [4:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic [7:0]  u0_a, u1_a;
    logic [31:0] u0_b, u1_b;

    // u0: A read-first direct, B write-first registered
    dpram_dual u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd), .a_rdata(u0_a),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd), .b_rdata(u0_b)
    );

    // u1: A no-change direct, B read-first direct
    dpram_dual #(
        .A_MODE(dpram_pkg::WM_NO_CHANGE), .B_MODE(dpram_pkg::WM_READ_FIRST), .B_OUT_REG(1'b0)
    ) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd), .a_rdata(u1_a),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd), .b_rdata(u1_b)
    );

    typedef struct {
        int          due;
        int          oid;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    logic [7:0]  model [NL];
    bit          valid [NL];
    logic [31:0] ev [4];
    bit          ek [4];
    int          checks = 0, errors = 0, cyc = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] actual(int oid);
        case (oid)
            0: return {24'd0, u0_a};
            1: return u0_b;
            2: return {24'd0, u1_a};
            default: return u1_b;
        endcase
    endfunction

    function automatic string oname(int oid);
        case (oid)
            0: return "u0.a";
            1: return "u0.b";
            2: return "u1.a";
            default: return "u1.b";
        endcase
    endfunction

    task automatic push(int due, int oid, string tag);
        if (ek[oid]) sbq.push_back('{due, oid, ev[oid], tag});
    endtask

    // monitor: compares every due item shortly after the edge
    always begin
        @(posedge clk);
        #1;
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                checks++;
                if (actual(sbq[i].oid) !== sbq[i].exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", sbq[i].tag,
                             oname(sbq[i].oid), actual(sbq[i].oid), sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    // driver: one operation per cycle on both ports
    task automatic op(bit ae, bit aw, int aa, logic [7:0] ad,
                      bit be, bit bw, int ba, logic [31:0] bd, string tag);
        logic [7:0]  old_a;
        logic [31:0] old_b;
        bit          ok_a, ok_b;
        @(negedge clk);
        a_en = ae; a_we = aw; a_addr = 7'(aa); a_wd = ad;
        b_en = be; b_we = bw; b_addr = 5'(ba); b_wd = bd;
        old_a = model[aa];
        ok_a  = valid[aa];
        ok_b  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            old_b[k*8 +: 8] = model[ba*4 + k];
            ok_b = ok_b & valid[ba*4 + k];
        end
        push(cyc + 1, 1, "R2");   // registered port still shows the previous result
        if (ae) begin
            ev[0] = old_a; ek[0] = ok_a;
            if (!aw) begin ev[2] = old_a; ek[2] = ok_a; end
        end
        if (be) begin
            ev[1] = bw ? bd : old_b; ek[1] = bw ? 1'b1 : ok_b;
            ev[3] = old_b; ek[3] = ok_b;
        end
        if (ae && aw) begin model[aa] = ad; valid[aa] = 1'b1; end
        if (be && bw) begin
            for (int k = 0; k < 4; k++) begin
                model[ba*4 + k] = bd[k*8 +: 8];
                valid[ba*4 + k] = 1'b1;
            end
        end
        push(cyc + 1, 0, tag);
        push(cyc + 1, 2, tag);
        push(cyc + 1, 3, tag);
        push(cyc + 2, 1, tag);
    endtask

    task automatic idle(string tag);
        op(0, 0, 0, 8'h00, 0, 0, 0, 32'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
        sbq.delete();
        @(negedge clk);
        @(negedge clk);
        for (int o = 0; o < 4; o++) begin
            checks++;
            if (actual(o) !== 32'h0) begin
                errors++;
                $display("FAIL R1 %s actual=%h expected=%h", oname(o), actual(o), 32'h0);
            end
            ev[o] = '0;
            ek[o] = 1'b1;
        end
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] pat(int l);
        return 8'((l * 7 + 3) ^ (l >> 3));
    endfunction

    function automatic logic [31:0] wpat(int w);
        return {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    endfunction

    initial begin
        for (int l = 0; l < NL; l++) begin model[l] = '0; valid[l] = 1'b0; end
        for (int o = 0; o < 4; o++) begin ev[o] = '0; ek[o] = 1'b1; end

        do_reset();                                        // R1

        // fill through the wide port (u0.b write-first)
        for (int w = 0; w < NW; w++) op(0, 0, 0, 8'h0, 1, 1, w, wpat(w), "R5");

        // narrow reads of every lane, wide reads in reverse order
        for (int l = 0; l < NL; l++) op(1, 0, l, 8'h0, 1, 0, 31 - l/4, 32'h0, "R7");

        // back-to-back wide reads of distinct words: latency per port
        for (int w = 0; w < 8; w++) op(1, 0, w*9, 8'h0, 1, 0, w*3, 32'h0, "R2");

        // narrow writes; wide port reads the same word at the same edge
        op(1, 1, 5,   8'hC5, 1, 0, 1,  32'h0, "R4 R6 R9");
        op(1, 1, 6,   8'hC6, 1, 0, 1,  32'h0, "R4 R6 R9");
        op(1, 1, 64,  8'h3A, 1, 0, 16, 32'h0, "R4 R6 R9");
        op(1, 1, 127, 8'hE1, 1, 0, 31, 32'h0, "R4 R6 R9");
        op(1, 1, 5,   8'h77, 0, 0, 0,  32'h0, "R4 R6");

        // wide reads show only the written lanes changed
        op(1, 0, 4, 8'h0, 1, 0, 1,  32'h0, "R8");
        op(1, 0, 6, 8'h0, 1, 0, 16, 32'h0, "R8");
        op(1, 0, 7, 8'h0, 1, 0, 31, 32'h0, "R8");

        // wide write while the narrow port reads a lane of that word
        op(1, 0, 42, 8'h0, 1, 1, 10, 32'hDEADBEEF, "R5 R9");
        op(1, 0, 42, 8'h0, 1, 0, 10, 32'h0,        "R9");
        op(1, 0, 41, 8'h0, 1, 1, 11, 32'h0BADF00D, "R5");
        op(1, 0, 44, 8'h0, 1, 0, 11, 32'h0,        "R4");

        // disabled ports with write enable high: no write, outputs hold
        op(0, 1, 3, 8'h55, 0, 1, 2, 32'h12345678, "R3");
        idle("R3");
        idle("R3");
        op(1, 0, 3, 8'h0, 1, 0, 2, 32'h0, "R3");
        op(0, 1, 8, 8'hAA, 0, 1, 0, 32'hFFFFFFFF, "R3");
        op(1, 0, 8, 8'h0, 1, 0, 0, 32'h0, "R3");

        // reset keeps the array
        do_reset();
        op(1, 0, 5,  8'h0, 1, 0, 16, 32'h0, "R10");
        op(1, 0, 43, 8'h0, 1, 0, 10, 32'h0, "R10");
        op(1, 0, 64, 8'h0, 1, 0, 31, 32'h0, "R10");

        idle("R3");
        idle("R3");
        idle("R3");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule